// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

A single 16-bit timing channel behind a small word-addressed register bus. Depending on two mode bits it either advances on ticks produced by an internal prescaler (timer modes) or on qualified transitions of an external event pin (counter modes). It can either wrap freely or reload from a programmed value each time it reaches its terminal count. The direction is set by a control bit or by an external direction pin.

Each terminal count can drive a timer output, either as a level that toggles or as a one-clock pulse. It can also set a sticky status flag that raises the interrupt request. Software sets up the prescaler and reload value first. It then sets the enable bit, and enabling copies the reload value into the counter. Both external pins pass through a synchronizer before they are used.

Top module: `tmrc_channel`

## Requirements
- R1: After reset, every register reads 0x0000, and `tmr_out` and `irq` are low.
- R2: Registers are word-aligned on byte addresses: control at 0x0, prescaler at 0x4, reload value at 0x8, status at 0xC (bit 0 only). The prescaler and reload registers read back the value written.
- R3: Control bits 15:12, 7 and 3 always read as zero.
- R4: In timer modes (control[11:10] = 00 free, 01 periodic) the counter takes one step every prescaler+1 clocks.
- R5: The terminal count is a step taken while the counter holds 0x0000 (counting down) or 0xFFFF (counting up). In periodic modes (control[10] = 1) that step reloads the counter, so a down-counting periodic timer with reload N and prescaler P has a terminal period of (N+1)*(P+1) clocks.
- R6: In free-running modes (control[10] = 0) the counter wraps at the terminal count: up from 0xFFFF to 0x0000, down from 0x0000 to 0xFFFF.
- R7: In counter modes (control[11:10] = 10 free, 11 periodic) the counter steps on edges of the synchronized `ext_evt` pin, as selected by control[9:8]: 00 rising, 01 falling, 10 both.
- R8: Edge selection control[9:8] = 11 makes the counter take no steps at all.
- R9: When control[5] = 0 the direction is control[4] (1 up, 0 down). When control[5] = 1 the direction is the synchronized `ext_dir` pin (1 up) and control[4] has no effect.
- R10: With control[6] = 0 the output level toggles at every terminal count. With control[6] = 1 it is high for exactly one clock per terminal count.
- R11: `tmr_out` is low unless both control[0] (enable) and control[2] (output enable) are set.
- R12: Status bit 0 is set at each terminal count while control[1] and control[0] are both set, and `irq` equals it. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R13: A 0-to-1 change of control[0] loads the counter from the reload register, and stepping begins on the following clock. The first terminal count of a periodic timer therefore appears 1+(N+1)*(P+1) clocks after the enabling write.
- R14: While control[0] is 0 the counter holds its value and no terminal count occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not selected) |
| ext_evt | input | 1 | Asynchronous external event pin |
| ext_dir | input | 1 | Asynchronous external direction pin (1 = up) |
| tmr_out | output | 1 | Timer output |
| irq | output | 1 | Interrupt request, equal to the sticky status flag |

## Verification
The properties assume that bus accesses occupy one clock each, and that writes to the status register only clear the flag and never collide with a control change that would make their effect ambiguous. The bench keeps to this by issuing one access per clock from a task.

Both asynchronous pins are held stable for at least six clocks around every change. This lets each transition pass through the synchronizer and be counted exactly once before the next one arrives, so every edge-count expectation stays deterministic.

// File: rtl/tmrc_pkg.sv
package tmrc_pkg;

  localparam int CTRL_W = 16;

  // register word indices (byte address bits [3:2])
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_PSC  = 2'd1;
  localparam logic [1:0] IDX_LOAD = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  typedef enum logic [1:0] {
    MODE_FREE_TMR = 2'b00,
    MODE_PER_TMR  = 2'b01,
    MODE_FREE_CNT = 2'b10,
    MODE_PER_CNT  = 2'b11
  } tmrc_mode_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } tmrc_edge_e;

  typedef struct packed {
    tmrc_mode_e mode;
    tmrc_edge_e edge_sel;
    logic       pulse_out;
    logic       dir_ext;
    logic       dir_up;
    logic       out_en;
    logic       irq_en;
    logic       run_en;
  } tmrc_ctrl_t;

  localparam tmrc_ctrl_t CTRL_RESET = tmrc_ctrl_t'(0);

  function automatic tmrc_ctrl_t word_to_ctrl(input logic [CTRL_W-1:0] w);
    tmrc_ctrl_t c;
    c.mode      = tmrc_mode_e'(w[11:10]);
    c.edge_sel  = tmrc_edge_e'(w[9:8]);
    c.pulse_out = w[6];
    c.dir_ext   = w[5];
    c.dir_up    = w[4];
    c.out_en    = w[2];
    c.irq_en    = w[1];
    c.run_en    = w[0];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_to_word(input tmrc_ctrl_t c);
    logic [CTRL_W-1:0] w;
    w        = '0;
    w[11:10] = c.mode;
    w[9:8]   = c.edge_sel;
    w[6]     = c.pulse_out;
    w[5]     = c.dir_ext;
    w[4]     = c.dir_up;
    w[2]     = c.out_en;
    w[1]     = c.irq_en;
    w[0]     = c.run_en;
    return w;
  endfunction

endpackage

// File: rtl/tmrc_regs.sv
module tmrc_regs
  import tmrc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              term_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output tmrc_ctrl_t        ctrl,
  output logic [PSC_W-1:0]  psc_val,
  output logic [CNT_W-1:0]  load_val,
  output logic              irq_pend
);

  logic       hit;
  logic [1:0] idx;
  logic       wr_ctrl, wr_psc, wr_load, wr_stat;

  tmrc_ctrl_t        ctrl_q, ctrl_d;
  logic [PSC_W-1:0]  psc_q, psc_d;
  logic [CNT_W-1:0]  load_q, load_d;
  logic              stat_q, stat_d;

  // decode: aligned words only, nothing above the four-register window
  assign hit     = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign idx     = bus_addr[3:2];
  assign wr_ctrl = hit && bus_wr && (idx == IDX_CTRL);
  assign wr_psc  = hit && bus_wr && (idx == IDX_PSC);
  assign wr_load = hit && bus_wr && (idx == IDX_LOAD);
  assign wr_stat = hit && bus_wr && (idx == IDX_STAT);

  always_comb begin
    ctrl_d = ctrl_q;
    psc_d  = psc_q;
    load_d = load_q;
    if (wr_ctrl) ctrl_d = word_to_ctrl(bus_wdata[CTRL_W-1:0]);
    if (wr_psc)  psc_d  = bus_wdata[PSC_W-1:0];
    if (wr_load) load_d = bus_wdata[CNT_W-1:0];
    // a new terminal event wins over a simultaneous clear
    stat_d = (stat_q && !(wr_stat && bus_wdata[0]))
           || (term_evt && ctrl_q.irq_en && ctrl_q.run_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      psc_q  <= '0;
      load_q <= '0;
      stat_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      psc_q  <= psc_d;
      load_q <= load_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_wr) begin
      unique case (idx)
        IDX_CTRL: bus_rdata = DATA_W'(ctrl_to_word(ctrl_q));
        IDX_PSC:  bus_rdata = DATA_W'(psc_q);
        IDX_LOAD: bus_rdata = DATA_W'(load_q);
        IDX_STAT: bus_rdata = DATA_W'(stat_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign ctrl     = ctrl_q;
  assign psc_val  = psc_q;
  assign load_val = load_q;
  assign irq_pend = stat_q;

endmodule

// File: rtl/tmrc_step.sv
module tmrc_step
  import tmrc_pkg::*;
#(
  parameter int PSC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             timer_mode,
  input  tmrc_edge_e       edge_sel,
  input  logic [PSC_W-1:0] psc_val,
  input  logic             ext_evt,
  input  logic             ext_dir,
  output logic             step,
  output logic             dir_sync
);

  logic [SYNC_STAGES-1:0] evt_sh_q, evt_sh_d;
  logic [SYNC_STAGES-1:0] dir_sh_q, dir_sh_d;
  logic                   evt_prev_q;
  logic                   evt_s;
  logic [PSC_W-1:0]       pcnt_q, pcnt_d;
  logic                   tick;
  logic                   rise, fall, edge_hit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      assign evt_sh_d = ext_evt;
      assign dir_sh_d = ext_dir;
    end else begin : g_syncn
      assign evt_sh_d = {evt_sh_q[SYNC_STAGES-2:0], ext_evt};
      assign dir_sh_d = {dir_sh_q[SYNC_STAGES-2:0], ext_dir};
    end
  endgenerate

  assign evt_s    = evt_sh_q[SYNC_STAGES-1];
  assign dir_sync = dir_sh_q[SYNC_STAGES-1];

  // prescaler: one tick every psc_val+1 clocks while running
  assign tick = run && (pcnt_q == psc_val);

  always_comb begin
    if (!run || tick) pcnt_d = '0;
    else              pcnt_d = pcnt_q + 1'b1;
  end

  assign rise = evt_s && !evt_prev_q;
  assign fall = !evt_s && evt_prev_q;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise || fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign step = run && (timer_mode ? tick : edge_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_sh_q   <= '0;
      dir_sh_q   <= '0;
      evt_prev_q <= 1'b0;
      pcnt_q     <= '0;
    end else begin
      evt_sh_q   <= evt_sh_d;
      dir_sh_q   <= dir_sh_d;
      evt_prev_q <= evt_s;
      pcnt_q     <= pcnt_d;
    end
  end

endmodule

// File: rtl/tmrc_core.sv
module tmrc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic             count_up,
  input  logic             periodic,
  input  logic             pulse_mode,
  input  logic [CNT_W-1:0] load_val,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             term_evt,
  output logic             out_lvl
);

  logic             en_q;
  logic             start;
  logic             at_term;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;

  assign start   = enable && !en_q;
  assign run     = enable && en_q;
  assign at_term = count_up ? (&cnt_q) : (cnt_q == '0);
  assign term_evt = step && at_term;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = load_val;
    end else if (step) begin
      if (at_term && periodic) cnt_d = load_val;
      else if (count_up)       cnt_d = cnt_q + 1'b1;
      else                     cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    if (pulse_mode) out_d = term_evt;
    else            out_d = term_evt ? !out_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      en_q  <= enable;
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign cnt     = cnt_q;
  assign out_lvl = out_q;

endmodule

// File: rtl/tmrc_channel.sv
module tmrc_channel
  import tmrc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_evt,
  input  logic              ext_dir,
  output logic              tmr_out,
  output logic              irq
);

  tmrc_ctrl_t       ctrl;
  logic [PSC_W-1:0] psc_val;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             run, step, dir_sync, count_up, periodic, timer_mode;
  logic             term_evt, out_lvl, irq_pend;

  assign timer_mode = (ctrl.mode == MODE_FREE_TMR) || (ctrl.mode == MODE_PER_TMR);
  assign periodic   = (ctrl.mode == MODE_PER_TMR)  || (ctrl.mode == MODE_PER_CNT);
  assign count_up   = ctrl.dir_ext ? dir_sync : ctrl.dir_up;

  tmrc_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .term_evt (term_evt),
    .bus_rdata(bus_rdata),
    .ctrl     (ctrl),
    .psc_val  (psc_val),
    .load_val (load_val),
    .irq_pend (irq_pend)
  );

  tmrc_step #(
    .PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .timer_mode(timer_mode),
    .edge_sel  (ctrl.edge_sel),
    .psc_val   (psc_val),
    .ext_evt   (ext_evt),
    .ext_dir   (ext_dir),
    .step      (step),
    .dir_sync  (dir_sync)
  );

  tmrc_core #(
    .CNT_W(CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl.run_en),
    .step      (step),
    .count_up  (count_up),
    .periodic  (periodic),
    .pulse_mode(ctrl.pulse_out),
    .load_val  (load_val),
    .run       (run),
    .cnt       (cnt),
    .term_evt  (term_evt),
    .out_lvl   (out_lvl)
  );

  assign tmr_out = out_lvl && ctrl.run_en && ctrl.out_en;
  assign irq     = irq_pend;

endmodule

// File: rtl/tmrc_channel_chk.sv
module tmrc_channel_chk
  import tmrc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input tmrc_ctrl_t        ctrl,
  input logic              run,
  input logic              step,
  input logic              count_up,
  input logic              periodic,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_val,
  input logic              term_evt,
  input logic              irq
);

  logic stat_clr, ctrl_rd;
  assign stat_clr = bus_sel && bus_wr && (bus_addr == 4'hC) && bus_wdata[0];
  assign ctrl_rd  = bus_sel && !bus_wr && (bus_addr == 4'h0);

  // R3: reserved control bits read as zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |-> (bus_rdata[15:12] == 4'h0 && !bus_rdata[7] && !bus_rdata[3]));

  // R12: status is sticky until a write of 1
  a_r12_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !stat_clr) |=> irq);

  // R12: status only rises after an enabled terminal count
  a_r12_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(term_evt && ctrl.irq_en && ctrl.run_en));

  // R5: periodic terminal count reloads
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (term_evt && periodic) |=> (cnt == $past(load_val)));

  // R6: free-running down count wraps to all ones
  a_r6_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !periodic && !count_up && cnt == '0) |=> (&cnt));

  // R8: unused edge selection takes no steps
  a_r8_no_edge_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl.mode[1] && ctrl.edge_sel == EDGE_NONE) |=> $stable(cnt));

  // R14: disabled channel holds its count
  a_r14_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run_en |=> $stable(cnt));

endmodule

bind tmrc_channel tmrc_channel_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ctrl     (ctrl),
  .run      (run),
  .step     (step),
  .count_up (count_up),
  .periodic (periodic),
  .cnt      (cnt),
  .load_val (load_val),
  .term_evt (term_evt),
  .irq      (irq)
);

// File: tb/tmrc_channel_tb.sv
`timescale 1ns/100ps
module tmrc_channel_tb;

  localparam logic [3:0] A_CTRL = 4'h0, A_PSC = 4'h4, A_LOAD = 4'h8, A_STAT = 4'hC;
  localparam logic [15:0] TE = 16'h0001, IE = 16'h0002, OE = 16'h0004, UD = 16'h0010,
                          UDS = 16'h0020, OM = 16'h0040, ES_F = 16'h0100, ES_B = 16'h0200,
                          ES_X = 16'h0300, M_PT = 16'h0400, M_FC = 16'h0800, M_PC = 16'h0C00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        ext_evt, ext_dir;
  logic        tmr_out, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmrc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_evt(ext_evt), .ext_dir(ext_dir), .tmr_out(tmr_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic cfg(input logic [15:0] psc, input logic [15:0] ld, input logic [15:0] c);
    wr(A_CTRL, 16'h0);
    wr(A_STAT, 16'h1);
    wr(A_PSC, psc);
    wr(A_LOAD, ld);
    wr(A_CTRL, c);
  endtask

  task automatic until_high(output int n, input int limit);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tmr_out !== 1'b1 && n < limit);
  endtask

  task automatic until_change(output int n, input int limit);
    logic lvl;
    lvl = tmr_out;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (tmr_out === lvl && n < limit);
  endtask

  task automatic evt_level(input logic v);
    @(negedge clk);
    ext_evt = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 tmr_out after reset", tmr_out, 0);
    chk("R1 irq after reset", irq, 0);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 0);
    rd(A_PSC, d);  chk("R1 psc reset", d, 0);
    rd(A_LOAD, d); chk("R1 load reset", d, 0);
    rd(A_STAT, d); chk("R1 status reset", d, 0);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(A_PSC, 16'h1234);  rd(A_PSC, d);  chk("R2 psc readback", d, 16'h1234);
    wr(A_LOAD, 16'hBEEF); rd(A_LOAD, d); chk("R2 load readback", d, 16'hBEEF);
    wr(A_CTRL, 16'hFFFF); rd(A_CTRL, d); chk("R3 reserved bits zero", d, 16'h0F77);
    wr(A_CTRL, 16'h0000); rd(A_CTRL, d); chk("R2 ctrl cleared", d, 16'h0000);
  endtask

  task automatic t_enable_period;
    int n;
    cfg(16'd2, 16'd3, TE | OE | OM | M_PT);
    until_high(n, 200);
    chk("R13 first terminal after enable", n, 13);
    @(negedge clk);
    chk("R10 pulse width one clock", tmr_out, 0);
    until_high(n, 200);
    chk("R4 R5 prescaled periodic gap", n + 1, 12);
  endtask

  task automatic t_toggle;
    int n;
    cfg(16'd1, 16'd1, TE | OE | M_PT);
    until_change(n, 200);
    chk("R10 first toggle", n, 5);
    until_change(n, 200);
    chk("R10 toggle interval a", n, 4);
    until_change(n, 200);
    chk("R10 toggle interval b", n, 4);
  endtask

  task automatic t_up_periodic;
    int n;
    cfg(16'd0, 16'hFFFC, TE | OE | OM | UD | M_PT);
    until_high(n, 200);
    chk("R9 R5 up periodic first", n, 5);
    until_high(n, 200);
    chk("R9 R5 up periodic gap", n, 4);
  endtask

  task automatic t_free_wrap;
    int n;
    cfg(16'd0, 16'hFFFD, TE | OE | OM | UD);
    until_high(n, 200);
    chk("R6 free up first terminal", n, 4);
    until_high(n, 70000);
    chk("R6 free up wrap gap", n, 65536);
  endtask

  task automatic t_gating;
    int seen_out;
    int seen_irq;
    cfg(16'd0, 16'd1, TE | IE | OM | M_PT);
    seen_out = 0;
    repeat (12) begin
      @(negedge clk);
      if (tmr_out !== 1'b0) seen_out++;
    end
    chk("R11 output held low without OE", seen_out, 0);
    chk("R12 status set with IE", irq, 1);
    wr(A_STAT, 16'h0);
    chk("R12 write 0 keeps status", irq, 1);
    wr(A_CTRL, TE | OE | OM | M_PT);
    wr(A_STAT, 16'h1);
    chk("R12 write 1 clears status", irq, 0);
    seen_out = 0;
    seen_irq = 0;
    repeat (12) begin
      @(negedge clk);
      if (tmr_out === 1'b1) seen_out++;
      if (irq !== 1'b0) seen_irq++;
    end
    chk("R12 no set with IE off", seen_irq, 0);
    chk("R11 pulses visible with OE", seen_out > 0, 1);
  endtask

  task automatic t_disabled;
    int seen;
    cfg(16'd0, 16'd0, TE | OE | OM | IE | M_PT);
    wr(A_CTRL, OE | OM | IE | M_PT);
    wr(A_STAT, 16'h1);
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (tmr_out !== 1'b0 || irq !== 1'b0) seen++;
    end
    chk("R14 disabled channel silent", seen, 0);
  endtask

  task automatic t_edges;
    cfg(16'd0, 16'd3, TE | IE | M_PC);
    for (int i = 1; i <= 4; i++) begin
      evt_level(1'b1);
      chk($sformatf("R7 rising edge %0d", i), irq, (i == 4));
      evt_level(1'b0);
    end
    cfg(16'd0, 16'd3, TE | IE | ES_F | M_FC);
    for (int i = 1; i <= 4; i++) begin
      evt_level(1'b1);
      chk($sformatf("R7 falling mode ignores rise %0d", i), irq, 0);
      evt_level(1'b0);
      chk($sformatf("R7 falling edge %0d", i), irq, (i == 4));
    end
    cfg(16'd0, 16'd3, TE | IE | ES_B | M_PC);
    for (int i = 1; i <= 2; i++) begin
      evt_level(1'b1);
      chk($sformatf("R7 both edges rise %0d", i), irq, 0);
      evt_level(1'b0);
      chk($sformatf("R7 both edges fall %0d", i), irq, (i == 2));
    end
  endtask

  task automatic t_no_edge;
    cfg(16'd0, 16'd0, TE | IE | ES_X | M_PC);
    for (int i = 1; i <= 3; i++) begin
      evt_level(1'b1);
      evt_level(1'b0);
      chk($sformatf("R8 unused edge select pulse %0d", i), irq, 0);
    end
  endtask

  task automatic t_ext_dir;
    ext_dir = 1'b1;
    repeat (4) @(negedge clk);
    cfg(16'd0, 16'hFFFE, TE | IE | UDS | M_PC);
    evt_level(1'b1); evt_level(1'b0);
    chk("R9 ext up after one edge", irq, 0);
    evt_level(1'b1); evt_level(1'b0);
    chk("R9 ext up terminal on second edge", irq, 1);
    ext_dir = 1'b0;
    repeat (4) @(negedge clk);
    cfg(16'd0, 16'hFFFE, TE | IE | UDS | UD | M_PC);
    for (int i = 0; i < 3; i++) begin
      evt_level(1'b1);
      evt_level(1'b0);
    end
    chk("R9 ext down overrides ctrl up bit", irq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_evt = 1'b0; ext_dir = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable_period();
    t_toggle();
    t_up_periodic();
    t_free_wrap();
    t_gating();
    t_disabled();
    t_edges();
    t_no_edge();
    t_ext_dir();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule